// File: doc/BRIEF.md
# Priority Reference Selector

This block picks the active timing reference for one phase-locked loop out of a set of candidate clock inputs. Upstream activity monitors and frequency-offset monitors each flag a failure per input. A small set of loss-of-signal pins can each be steered onto any input. An input is usable only when none of these sources flags it. A programmable priority per input then ranks the usable ones, and a compact state machine applies the host's policy to that ranking. The host can pin the selection to one input, which overrides everything. Otherwise the block either stays on the current reference while it remains usable (non-revertive), or moves back to a better one once that input has stayed good through a wait-to-restore interval measured in external ticks (revertive).

The outputs are the selected index, a flag that no input is usable, a one-cycle pulse on every change of index, and a status bit that reports a forced selection pointing at an unusable input. All outputs are registered and react at the first clock edge after an input change. The reset input is asserted asynchronously and released through an internal two-stage synchronizer.

Top module: `ref_priority_sel`

## Requirements
- R1: While reset is held, sel_idx_o is 0, no_valid_o is 1, and switch_o and force_bad_o are 0.
- R2: Input i is qualified only when act_fail_i[i], freq_fail_i[i] and every loss pin mapped to it are all 0. A qualified input whose priority field is 0 is never chosen automatically.
- R3: Loss pin p targets the input whose index is held in los_map_i[4p+3:4p], and only while los_en_i[p] is 1. A high pin with its enable at 0 has no effect on any input.
- R4: The priority field of input i is prio_i[4i+3:4i]. Among the qualified inputs with a nonzero field, the automatic choice is the one with the smallest value, and on equal values the one with the lowest index. sel_idx_o always stays below the number of inputs.
- R5: With revert_en_i at 0 and no force, the current reference is kept while it stays qualified with a nonzero priority, even when a better input is available.
- R6: With revert_en_i at 1, an input with a strictly smaller priority value replaces the current reference only after wtr_limit_i ticks (cycles with tick_i at 1) have been counted while some better input was present. The switch happens at the first edge at which the count has reached the limit. A limit of 0 switches at the first edge.
- R7: When the current reference loses qualification, the best qualified input is selected at the next clock edge.
- R8: When no input is qualified with a nonzero priority, no_valid_o is 1 one edge later, and sel_idx_o keeps its last value unless a force applies.
- R9: While force_en_i is 1, sel_idx_o follows force_idx_i one edge later, whatever the qualification. An index of 12 or more leaves the selection unchanged. force_bad_o is 1 when the forced index is out of range or points at a disqualified input. After release, the forced input counts as the current reference.
- R10: switch_o is 1 for exactly the cycles in which sel_idx_o differs from its value one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_fail_i | input | NUM_REF | Per-input activity monitor failure flags |
| freq_fail_i | input | NUM_REF | Per-input frequency-offset monitor failure flags |
| los_i | input | NUM_LOS | Loss-of-signal pins, 1 = loss |
| los_en_i | input | NUM_LOS | Per-pin mapping enable |
| los_map_i | input | NUM_LOS*IDX_W | Target input index per loss pin |
| prio_i | input | NUM_REF*PRIO_W | Priority per input, 0 = excluded, smaller = preferred |
| force_en_i | input | 1 | Forced selection enable |
| force_idx_i | input | IDX_W | Forced input index |
| revert_en_i | input | 1 | 1 = revertive, 0 = non-revertive |
| wtr_limit_i | input | WTR_W | Wait-to-restore length in ticks |
| tick_i | input | 1 | Wait-to-restore time base strobe |
| sel_idx_o | output | IDX_W | Selected input index |
| no_valid_o | output | 1 | No usable input |
| switch_o | output | 1 | One-cycle pulse on index change |
| force_bad_o | output | 1 | Forced input is disqualified or out of range |

## Verification
The bench builds the selector with twelve inputs, four loss pins, 4-bit priority fields and an 8-bit wait-to-restore counter. With that small counter, the tick-accurate revert point can be reached in a handful of cycles. The full index span of 4 bits also leaves indices 12 to 15 free to exercise an out-of-range force. The priority table used by the bench contains equal values and zero entries, and one loss pin is mapped with its enable cleared. This lets the tie-break, the exclusion rule and the ignored pin each be seen at sel_idx_o.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_LOCK  = 2'd1,
    MODE_FORCE = 2'd2
  } sel_mode_t;
endpackage

// File: rtl/refsel_rst_sync.sv
module refsel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/refsel_qualify.sv
module refsel_qualify #(
  parameter int NUM_REF = 12,
  parameter int NUM_LOS = 4,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_REF-1:0]        act_fail_i,
  input  logic [NUM_REF-1:0]        freq_fail_i,
  input  logic [NUM_LOS-1:0]        los_i,
  input  logic [NUM_LOS-1:0]        los_en_i,
  input  logic [NUM_LOS*IDX_W-1:0]  los_map_i,
  input  logic [NUM_REF*PRIO_W-1:0] prio_i,
  output logic [NUM_REF-1:0]        qual_o,
  output logic [NUM_REF-1:0]        cand_o
);
  for (genvar r = 0; r < NUM_REF; r++) begin : g_ref
    logic los_hit;

    always_comb begin
      los_hit = 1'b0;
      for (int p = 0; p < NUM_LOS; p++) begin
        if (los_en_i[p] && los_i[p] &&
            (los_map_i[p*IDX_W +: IDX_W] == IDX_W'(r)))
          los_hit = 1'b1;
      end
    end

    assign qual_o[r] = ~act_fail_i[r] & ~freq_fail_i[r] & ~los_hit;
    assign cand_o[r] = qual_o[r] & (prio_i[r*PRIO_W +: PRIO_W] != '0);
  end
endmodule

// File: rtl/refsel_rank.sv
module refsel_rank #(
  parameter int NUM_REF = 12,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_REF-1:0]        cand_i,
  input  logic [NUM_REF*PRIO_W-1:0] prio_i,
  output logic                      best_vld_o,
  output logic [IDX_W-1:0]          best_idx_o,
  output logic [PRIO_W-1:0]         best_prio_o
);
  always_comb begin
    best_vld_o  = 1'b0;
    best_idx_o  = '0;
    best_prio_o = '1;
    for (int i = 0; i < NUM_REF; i++) begin
      if (cand_i[i] &&
          (!best_vld_o || (prio_i[i*PRIO_W +: PRIO_W] < best_prio_o))) begin
        best_vld_o  = 1'b1;
        best_idx_o  = IDX_W'(i);
        best_prio_o = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/refsel_wtr.sv
module refsel_wtr #(
  parameter int WTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [WTR_W-1:0] limit_i,
  output logic             done_o
);
  logic [WTR_W-1:0] cnt_q;
  logic [WTR_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr_i | (tick_i & (cnt_q != '1));

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q >= limit_i);
endmodule

// File: rtl/ref_priority_sel.sv
module ref_priority_sel
  import refsel_pkg::*;
#(
  parameter int NUM_REF = 12,
  parameter int NUM_LOS = 4,
  parameter int PRIO_W  = 4,
  parameter int WTR_W   = 16,
  parameter int IDX_W   = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REF-1:0]        act_fail_i,
  input  logic [NUM_REF-1:0]        freq_fail_i,
  input  logic [NUM_LOS-1:0]        los_i,
  input  logic [NUM_LOS-1:0]        los_en_i,
  input  logic [NUM_LOS*IDX_W-1:0]  los_map_i,
  input  logic [NUM_REF*PRIO_W-1:0] prio_i,
  input  logic                      force_en_i,
  input  logic [IDX_W-1:0]          force_idx_i,
  input  logic                      revert_en_i,
  input  logic [WTR_W-1:0]          wtr_limit_i,
  input  logic                      tick_i,
  output logic [IDX_W-1:0]          sel_idx_o,
  output logic                      no_valid_o,
  output logic                      switch_o,
  output logic                      force_bad_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REF - 1);

  logic                rst_sync_n;
  logic [NUM_REF-1:0]  qual;
  logic [NUM_REF-1:0]  cand;
  logic                best_vld;
  logic [IDX_W-1:0]    best_idx;
  logic [PRIO_W-1:0]   best_prio;
  logic [PRIO_W-1:0]   cur_prio;
  logic                cur_cand;
  logic                cur_ok;
  logic                better;
  logic                force_ok_idx;
  logic                force_qual;
  logic                wtr_clr;
  logic                wtr_done;

  sel_mode_t           mode_q, mode_d;
  logic [IDX_W-1:0]    sel_q, sel_d;
  logic                nv_q, nv_d;
  logic                sw_q, sw_d;
  logic                fb_q, fb_d;

  refsel_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  refsel_qualify #(
    .NUM_REF (NUM_REF),
    .NUM_LOS (NUM_LOS),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
  ) u_qual (
    .act_fail_i  (act_fail_i),
    .freq_fail_i (freq_fail_i),
    .los_i       (los_i),
    .los_en_i    (los_en_i),
    .los_map_i   (los_map_i),
    .prio_i      (prio_i),
    .qual_o      (qual),
    .cand_o      (cand)
  );

  refsel_rank #(
    .NUM_REF (NUM_REF),
    .PRIO_W  (PRIO_W),
    .IDX_W   (IDX_W)
  ) u_rank (
    .cand_i      (cand),
    .prio_i      (prio_i),
    .best_vld_o  (best_vld),
    .best_idx_o  (best_idx),
    .best_prio_o (best_prio)
  );

  refsel_wtr #(
    .WTR_W (WTR_W)
  ) u_wtr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (wtr_clr),
    .tick_i  (tick_i),
    .limit_i (wtr_limit_i),
    .done_o  (wtr_done)
  );

  // Look up the state of the current and the forced input
  always_comb begin
    cur_prio   = '0;
    cur_cand   = 1'b0;
    force_qual = 1'b0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (sel_q == IDX_W'(i)) begin
        cur_prio = prio_i[i*PRIO_W +: PRIO_W];
        cur_cand = cand[i];
      end
      if (force_idx_i == IDX_W'(i))
        force_qual = qual[i];
    end
  end

  assign force_ok_idx = (force_idx_i <= LAST_IDX);
  assign cur_ok       = (mode_q != MODE_NONE) && cur_cand;
  assign better       = best_vld && (best_prio < cur_prio);

  // Next-state logic of the selection machine
  always_comb begin
    mode_d  = mode_q;
    sel_d   = sel_q;
    wtr_clr = 1'b1;
    if (force_en_i) begin
      mode_d = MODE_FORCE;
      if (force_ok_idx) sel_d = force_idx_i;
    end else if (cur_ok) begin
      mode_d = MODE_LOCK;
      if (revert_en_i && better) begin
        wtr_clr = wtr_done;
        if (wtr_done) sel_d = best_idx;
      end
    end else if (best_vld) begin
      mode_d = MODE_LOCK;
      sel_d  = best_idx;
    end else begin
      mode_d = MODE_NONE;
    end

    nv_d = ~best_vld;
    sw_d = (sel_d != sel_q);
    fb_d = force_en_i & (~force_ok_idx | ~force_qual);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= MODE_NONE;
      sel_q  <= '0;
      nv_q   <= 1'b1;
      sw_q   <= 1'b0;
      fb_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
      nv_q   <= nv_d;
      sw_q   <= sw_d;
      fb_q   <= fb_d;
    end
  end

  assign sel_idx_o   = sel_q;
  assign no_valid_o  = nv_q;
  assign switch_o    = sw_q;
  assign force_bad_o = fb_q;
endmodule

// File: rtl/ref_priority_sel_chk.sv
module ref_priority_sel_chk #(
  parameter int NUM_REF = 12,
  parameter int IDX_W   = 4
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               force_en_i,
  input logic [IDX_W-1:0]   force_idx_i,
  input logic               revert_en_i,
  input logic [NUM_REF-1:0] cand,
  input logic               cur_ok,
  input logic [IDX_W-1:0]   sel_idx_o,
  input logic               no_valid_o,
  input logic               switch_o,
  input logic               force_bad_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REF - 1);

  // R10
  switch_on_change_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_idx_o != $past(sel_idx_o)) |-> switch_o);

  // R10
  switch_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    switch_o |-> (sel_idx_o != $past(sel_idx_o)));

  // R9
  force_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (force_en_i && (force_idx_i <= LAST_IDX)) |=> (sel_idx_o == $past(force_idx_i)));

  // R9
  force_bad_src_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    force_bad_o |-> $past(force_en_i));

  // R8
  none_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!force_en_i && (cand == '0)) |=> $stable(sel_idx_o));

  // R8
  none_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cand == '0) |=> no_valid_o);

  // R5
  nonrev_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!force_en_i && !revert_en_i && cur_ok) |=> $stable(sel_idx_o));

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_idx_o <= LAST_IDX);
endmodule

bind ref_priority_sel ref_priority_sel_chk #(
  .NUM_REF (NUM_REF),
  .IDX_W   (IDX_W)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .force_en_i  (force_en_i),
  .force_idx_i (force_idx_i),
  .revert_en_i (revert_en_i),
  .cand        (cand),
  .cur_ok      (cur_ok),
  .sel_idx_o   (sel_idx_o),
  .no_valid_o  (no_valid_o),
  .switch_o    (switch_o),
  .force_bad_o (force_bad_o)
);

// File: tb/tb_ref_priority_sel.sv
`timescale 1ns/1ps
module tb_ref_priority_sel;
  localparam int NREF  = 12;
  localparam int NLOS  = 4;
  localparam int PW    = 4;
  localparam int WW    = 8;
  localparam int IW    = 4;

  logic            clk;
  logic            rst_n;
  logic [NREF-1:0] act_fail, freq_fail;
  logic [NLOS-1:0] los, los_en;
  logic [NLOS*IW-1:0] los_map;
  logic [NREF*PW-1:0] prio;
  logic            force_en, revert_en, tick;
  logic [IW-1:0]   force_idx;
  logic [WW-1:0]   wtr_limit;
  logic [IW-1:0]   sel_idx;
  logic            no_valid, sw, force_bad;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  ref_priority_sel #(
    .NUM_REF (NREF), .NUM_LOS (NLOS), .PRIO_W (PW), .WTR_W (WW)
  ) dut (
    .clk (clk), .rst_n (rst_n),
    .act_fail_i (act_fail), .freq_fail_i (freq_fail),
    .los_i (los), .los_en_i (los_en), .los_map_i (los_map),
    .prio_i (prio), .force_en_i (force_en), .force_idx_i (force_idx),
    .revert_en_i (revert_en), .wtr_limit_i (wtr_limit), .tick_i (tick),
    .sel_idx_o (sel_idx), .no_valid_o (no_valid), .switch_o (sw),
    .force_bad_o (force_bad)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {act_fail, freq_fail, los, expected index, expected no-valid}
  localparam logic [32:0] VEC [13] = '{
    {12'h000, 12'h000, 4'h0, 4'd5,  1'b0},
    {12'h020, 12'h000, 4'h0, 4'd10, 1'b0},
    {12'h000, 12'h020, 4'h0, 4'd10, 1'b0},
    {12'h000, 12'h000, 4'h1, 4'd10, 1'b0},
    {12'h000, 12'h000, 4'h3, 4'd6,  1'b0},
    {12'h000, 12'h000, 4'hB, 4'd6,  1'b0},
    {12'h040, 12'h000, 4'h3, 4'd2,  1'b0},
    {12'h040, 12'h000, 4'h7, 4'd3,  1'b0},
    {12'h068, 12'h400, 4'h4, 4'd9,  1'b0},
    {12'hF7E, 12'h000, 4'h0, 4'd9,  1'b1},
    {12'h7FF, 12'h000, 4'h0, 4'd11, 1'b0},
    {12'hFFF, 12'h000, 4'h0, 4'd11, 1'b1},
    {12'h000, 12'h000, 4'h0, 4'd5,  1'b0}
  };

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_idx(string req, logic [IW-1:0] exp);
    n_tests++;
    if (sel_idx !== exp) begin
      n_fail++;
      $display("FAIL %s sel_idx actual=%0d expected=%0d", req, sel_idx, exp);
    end
  endtask

  task automatic chk_bit(string req, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n     = 1'b0;
    act_fail  = '0;
    freq_fail = '0;
    los       = '0;
    los_en    = 4'b0111;               // pin 3 mapping disabled
    los_map   = 16'h62A5;              // pins 0..3 -> inputs 5, 10, 2, 6
    prio      = 48'hF14902173350;      // inputs 11..0: F,1,4,9,0,2,1,7,3,3,5,0
    force_en  = 1'b0;
    force_idx = '0;
    revert_en = 1'b1;
    wtr_limit = '0;
    tick      = 1'b0;

    repeat (3) step();
    // R1 reset state
    chk_idx("R1", 4'd0);
    chk_bit("R1", "no_valid", no_valid, 1'b1);
    chk_bit("R1", "switch", sw, 1'b0);
    chk_bit("R1", "force_bad", force_bad, 1'b0);

    // reset release through synchronizer; hold inputs all failed
    act_fail = '1;
    rst_n    = 1'b1;
    repeat (3) step();

    // R2 R3 R4 R7 R8: table walk, revertive with zero wait
    for (int v = 0; v < 13; v++) begin
      act_fail  = VEC[v][32:21];
      freq_fail = VEC[v][20:9];
      los       = VEC[v][8:5];
      step();
      chk_idx($sformatf("R4 vec%0d", v), VEC[v][4:1]);
      chk_bit($sformatf("R8 vec%0d", v), "no_valid", no_valid, VEC[v][0]);
    end

    // R5 non-revertive: fail 5, then restore it
    revert_en = 1'b0;
    act_fail  = 12'h020;
    step();
    chk_idx("R7", 4'd10);
    chk_bit("R10", "switch", sw, 1'b1);
    act_fail = '0;
    repeat (5) step();
    chk_idx("R5", 4'd10);
    chk_bit("R10", "switch", sw, 1'b0);

    // R6 equal priority is not better
    revert_en = 1'b1;
    wtr_limit = 8'd3;
    tick      = 1'b1;
    repeat (5) step();
    chk_idx("R6 tie", 4'd10);
    tick = 1'b0;

    // R7 failover, then R6 wait-to-restore
    act_fail = 12'h420;
    step();
    chk_idx("R7", 4'd6);
    chk_bit("R10", "switch", sw, 1'b1);
    step();
    chk_bit("R10", "switch", sw, 1'b0);
    act_fail = '0;
    repeat (4) step();
    chk_idx("R6 no ticks", 4'd6);
    tick = 1'b1;
    repeat (3) step();
    chk_idx("R6 count at limit", 4'd6);
    tick = 1'b0;
    step();
    chk_idx("R6 revert", 4'd5);
    chk_bit("R10", "switch", sw, 1'b1);
    step();
    chk_bit("R10", "switch", sw, 1'b0);

    // R9 forced selection
    force_en  = 1'b1;
    force_idx = 4'd7;
    step();
    chk_idx("R9", 4'd7);
    chk_bit("R9", "force_bad", force_bad, 1'b0);
    force_idx = 4'd4;
    act_fail  = 12'h010;
    step();
    chk_idx("R9 disqualified", 4'd4);
    chk_bit("R9", "force_bad", force_bad, 1'b1);
    force_idx = 4'd13;
    step();
    chk_idx("R9 out of range", 4'd4);
    chk_bit("R9", "force_bad", force_bad, 1'b1);
    chk_bit("R10", "switch", sw, 1'b0);
    force_en  = 1'b0;
    revert_en = 1'b0;
    act_fail  = '0;
    step();
    chk_idx("R9 release kept", 4'd4);
    chk_bit("R9", "force_bad", force_bad, 1'b0);

    // R8 nothing usable, hold
    act_fail = '1;
    repeat (3) step();
    chk_idx("R8 hold", 4'd4);
    chk_bit("R8", "no_valid", no_valid, 1'b1);
    act_fail = '0;
    step();
    chk_idx("R8 recover", 4'd5);
    chk_bit("R8", "no_valid", no_valid, 1'b0);

    // R1 reset mid-run
    rst_n = 1'b0;
    step();
    chk_idx("R1 rerun", 4'd0);
    chk_bit("R1", "no_valid", no_valid, 1'b1);
    chk_bit("R1", "switch", sw, 1'b0);

    finish_run();
  end
endmodule